// File: doc/BRIEF.md
# Pipelined SRAM Slave with Ready Countdown

This block is a memory slave that sits between a point-to-point on-chip command port and an asynchronous static RAM. The master pulses a read or a write strobe for a single cycle, together with address and write data. The slave captures everything it needs into its own registers, so the master never has to hold a request. The active-low chip select, output enable and write enable come straight from flip-flops, and the write data is driven onto the shared data bus only while write enable is low.

The slave does not answer with a late acknowledge. It reports a countdown instead: the number of cycles left until the read word sits on the read-data output, or until the write has finished. A value of zero means the result is valid in the current cycle. A constant pipeline-level output, fixed at build time, tells the master how early it may send the next command. At level 3 the slave holds a second command in a waiting slot while the RAM finishes the current one. The last read word stays on the output until a later read replaces it.

Top module: `sram_pipe_slave`

## Requirements
- R1: After reset, chip select, output enable and write enable are high (inactive), the countdown is 0, the read-data output is 0, and the pipeline-level output equals the build parameter PIPE_LVL.
- R2: A command that is accepted while the countdown is 0 shows a countdown of ACC_CYC (default 2) in the next cycle. The countdown then falls by one each cycle. For a read, the word appears on the read-data output in the first cycle where the countdown is 0.
- R3: A write holds chip select and write enable low for ACC_CYC cycles, and during those cycles the slave drives the captured write data onto the RAM data bus.
- R4: The read-data output keeps its value through writes and idle cycles, and changes only when a read completes.
- R5: Chip select is low exactly in the cycles where the countdown is nonzero. Output enable is low only for reads and write enable only for writes. The two are never low together.
- R6: A command is accepted only at the point the level permits. At level 0 the countdown must be 0 and the previous cycle must not be a result cycle (the cycle after a countdown of 1). At level 1 the countdown must be 0. At level 2 the countdown must be at most 1. At level 3 it must be at most 2.
- R7: A command presented outside that window, or with both strobes high, is ignored: the countdown, the RAM pins and the read data are unaffected by it.
- R8: A command accepted while the countdown is c ≥ 1 shows c + ACC_CYC − 1 in the next cycle. The countdown always reports the newest accepted command.
- R9: At level 3, an older read completes and places its word on the output before a newer, waiting read. Each word appears in the cycle the older countdown would have reached 0.
- R10: During a read, the captured address is on the RAM address pins and output enable is low for all ACC_CYC access cycles. The word is captured at the end of the last of these cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_rd | input | 1 | Single-cycle read strobe |
| cmd_wr | input | 1 | Single-cycle write strobe |
| cmd_addr | input | ADDR_W | Address, valid with a strobe |
| cmd_wdata | input | DATA_W | Write data, valid with the write strobe |
| cmd_rdata | output | DATA_W | Held read data |
| rdy_cnt | output | CNT_W | Cycles until the newest command's result |
| pipe_level | output | 2 | Constant pipeline level |
| sram_addr | output | ADDR_W | RAM address |
| sram_dq | inout | DATA_W | RAM bidirectional data |
| sram_ncs | output | 1 | RAM chip select, active low |
| sram_noe | output | 1 | RAM output enable, active low |
| sram_nwe | output | 1 | RAM write enable, active low |

## Verification
The hardest case to reach is the level-3 overlap. Here a second read sits in the waiting slot while the first still owns the RAM, the countdown climbs above ACC_CYC, and a third, premature strobe arrives in that same cycle. The stimulus issues the second read exactly one cycle after the first and keeps the strobe high into the following cycle. It then checks that both words come out in order and that the third command leaves no trace. A separate level-0 instance is held with its strobe high from the first busy cycle onward, which shows that it refuses both the busy cycles and the result cycle.

// File: rtl/sram_pipe_pkg.sv
package sram_pipe_pkg;

   typedef enum logic {
      KIND_READ  = 1'b0,
      KIND_WRITE = 1'b1
   } acc_kind_e;

   // Largest countdown value at which a new command may still be taken
   // for levels 1..3 (level 0 has an extra rule on the result cycle).
   function automatic int unsigned open_limit(input int unsigned lvl);
      return (lvl == 0) ? 0 : lvl - 1;
   endfunction

endpackage

// File: rtl/sps_gate.sv
module sps_gate
   import sram_pipe_pkg::*;
#(
   parameter int unsigned PIPE_LVL = 3,
   parameter int unsigned CNT_W    = 2
) (
   input  logic [CNT_W-1:0] cnt_q,
   input  logic             done_q,
   input  logic             rd,
   input  logic             wr,
   output logic             accept,
   output logic             to_pend
);
   localparam logic [CNT_W-1:0] TWO_V = CNT_W'(2);
   logic window_open;

   generate
      if (PIPE_LVL == 0) begin : g_no_overlap
         assign window_open = (cnt_q == '0) && !done_q;
      end else begin : g_overlap
         localparam logic [CNT_W-1:0] LIM_V = CNT_W'(open_limit(PIPE_LVL));
         assign window_open = (cnt_q <= LIM_V);
      end
   endgenerate

   assign accept  = (rd ^ wr) && window_open;
   assign to_pend = accept && (cnt_q >= TWO_V);
endmodule

// File: rtl/sps_countdown.sv
module sps_countdown #(
   parameter int unsigned ACC_CYC = 2,
   parameter int unsigned CNT_W   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] nxt_cnt,
   output logic             done_q,
   output logic             last_act,
   output logic             promote
);
   localparam logic [CNT_W-1:0] ONE_V = CNT_W'(1);
   localparam logic [CNT_W-1:0] ACC_V = CNT_W'(ACC_CYC);
   localparam logic [CNT_W-1:0] TOP_V = CNT_W'(ACC_CYC + 1);

   always_comb begin
      if (accept) begin
         nxt_cnt = (cnt_q == '0) ? ACC_V : cnt_q + ACC_V - ONE_V;
      end else if (cnt_q != '0) begin
         nxt_cnt = cnt_q - ONE_V;
      end else begin
         nxt_cnt = '0;
      end
   end

   assign promote  = (cnt_q == TOP_V);
   assign last_act = (cnt_q == ONE_V) || promote;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else begin
         cnt_q  <= nxt_cnt;
         done_q <= (cnt_q == ONE_V);
      end
   end
endmodule

// File: rtl/sps_slots.sv
module sps_slots
   import sram_pipe_pkg::*;
#(
   parameter int unsigned ADDR_W = 18,
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              to_pend,
   input  logic              promote,
   input  logic              cmd_is_wr,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [DATA_W-1:0] cmd_wdata,
   output logic [ADDR_W-1:0] act_addr,
   output logic [DATA_W-1:0] act_wdata,
   output acc_kind_e         act_kind,
   output acc_kind_e         nxt_kind
);
   logic [ADDR_W-1:0] pend_addr, nxt_addr;
   logic [DATA_W-1:0] pend_wdata, nxt_wdata;
   acc_kind_e         pend_kind, cmd_kind;

   assign cmd_kind = cmd_is_wr ? KIND_WRITE : KIND_READ;

   always_comb begin
      nxt_addr  = act_addr;
      nxt_wdata = act_wdata;
      nxt_kind  = act_kind;
      if (accept && !to_pend) begin
         nxt_addr  = cmd_addr;
         nxt_wdata = cmd_wdata;
         nxt_kind  = cmd_kind;
      end else if (promote) begin
         nxt_addr  = pend_addr;
         nxt_wdata = pend_wdata;
         nxt_kind  = pend_kind;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_addr   <= '0;
         act_wdata  <= '0;
         act_kind   <= KIND_READ;
         pend_addr  <= '0;
         pend_wdata <= '0;
         pend_kind  <= KIND_READ;
      end else begin
         act_addr  <= nxt_addr;
         act_wdata <= nxt_wdata;
         act_kind  <= nxt_kind;
         if (accept && to_pend) begin
            pend_addr  <= cmd_addr;
            pend_wdata <= cmd_wdata;
            pend_kind  <= cmd_kind;
         end
      end
   end
endmodule

// File: rtl/sps_pins.sv
module sps_pins
   import sram_pipe_pkg::*;
#(
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              nxt_busy,
   input  acc_kind_e         nxt_kind,
   input  acc_kind_e         act_kind,
   input  logic              last_act,
   input  logic [DATA_W-1:0] dq_in,
   output logic              ncs_q,
   output logic              noe_q,
   output logic              nwe_q,
   output logic [DATA_W-1:0] rdata_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ncs_q   <= 1'b1;
         noe_q   <= 1'b1;
         nwe_q   <= 1'b1;
         rdata_q <= '0;
      end else begin
         ncs_q <= !nxt_busy;
         noe_q <= !(nxt_busy && (nxt_kind == KIND_READ));
         nwe_q <= !(nxt_busy && (nxt_kind == KIND_WRITE));
         if (last_act && (act_kind == KIND_READ)) begin
            rdata_q <= dq_in;
         end
      end
   end
endmodule

// File: rtl/sram_pipe_slave.sv
module sram_pipe_slave
   import sram_pipe_pkg::*;
#(
   parameter int unsigned ADDR_W   = 18,
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned ACC_CYC  = 2,
   parameter int unsigned PIPE_LVL = 3,
   parameter int unsigned CNT_W    = $clog2(ACC_CYC + 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_rd,
   input  logic              cmd_wr,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [DATA_W-1:0] cmd_wdata,
   output logic [DATA_W-1:0] cmd_rdata,
   output logic [CNT_W-1:0]  rdy_cnt,
   output logic [1:0]        pipe_level,
   output logic [ADDR_W-1:0] sram_addr,
   inout  wire  [DATA_W-1:0] sram_dq,
   output logic              sram_ncs,
   output logic              sram_noe,
   output logic              sram_nwe
);
   generate
      if (PIPE_LVL > 3) begin : g_bad_level
         $error("PIPE_LVL must lie in 0..3");
      end
      if (ACC_CYC < 2) begin : g_bad_acc
         $error("ACC_CYC must be at least 2");
      end
      if (CNT_W < $clog2(ACC_CYC + 2)) begin : g_bad_cnt
         $error("CNT_W too narrow for ACC_CYC+1");
      end
   endgenerate

   logic             accept, to_pend, done_q, last_act, promote;
   logic [CNT_W-1:0] cnt_q, nxt_cnt;
   logic [DATA_W-1:0] act_wdata;
   acc_kind_e        act_kind, nxt_kind;

   sps_gate #(.PIPE_LVL(PIPE_LVL), .CNT_W(CNT_W)) u_gate (
      .cnt_q   (cnt_q),
      .done_q  (done_q),
      .rd      (cmd_rd),
      .wr      (cmd_wr),
      .accept  (accept),
      .to_pend (to_pend)
   );

   sps_countdown #(.ACC_CYC(ACC_CYC), .CNT_W(CNT_W)) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept   (accept),
      .cnt_q    (cnt_q),
      .nxt_cnt  (nxt_cnt),
      .done_q   (done_q),
      .last_act (last_act),
      .promote  (promote)
   );

   sps_slots #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_slots (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .to_pend   (to_pend),
      .promote   (promote),
      .cmd_is_wr (cmd_wr),
      .cmd_addr  (cmd_addr),
      .cmd_wdata (cmd_wdata),
      .act_addr  (sram_addr),
      .act_wdata (act_wdata),
      .act_kind  (act_kind),
      .nxt_kind  (nxt_kind)
   );

   sps_pins #(.DATA_W(DATA_W)) u_pins (
      .clk      (clk),
      .rst_n    (rst_n),
      .nxt_busy (nxt_cnt != '0),
      .nxt_kind (nxt_kind),
      .act_kind (act_kind),
      .last_act (last_act),
      .dq_in    (sram_dq),
      .ncs_q    (sram_ncs),
      .noe_q    (sram_noe),
      .nwe_q    (sram_nwe),
      .rdata_q  (cmd_rdata)
   );

   assign sram_dq    = !sram_nwe ? act_wdata : 'z;
   assign rdy_cnt    = cnt_q;
   assign pipe_level = 2'(PIPE_LVL);
endmodule

// File: rtl/sram_pipe_slave_chk.sv
module sram_pipe_slave_chk #(
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned ACC_CYC  = 2,
   parameter int unsigned PIPE_LVL = 3,
   parameter int unsigned CNT_W    = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [CNT_W-1:0]  rdy_cnt,
   input logic [DATA_W-1:0] cmd_rdata,
   input logic              sram_ncs,
   input logic              sram_noe,
   input logic              sram_nwe
);
   localparam int unsigned GATE = (PIPE_LVL == 0) ? 1 : PIPE_LVL;
   localparam logic [CNT_W-1:0] GATE_V = CNT_W'(GATE);
   localparam logic [CNT_W-1:0] ACC_V  = CNT_W'(ACC_CYC);
   localparam logic [CNT_W-1:0] TOP_V  = CNT_W'(ACC_CYC + 1);

   assert_idle_ctrl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sram_ncs |-> (sram_noe && sram_nwe));

   assert_no_dual_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(!sram_noe && !sram_nwe));

   assert_select_tracks_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rdy_cnt != '0) == !sram_ncs);

   assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rdy_cnt <= TOP_V);

   assert_closed_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rdy_cnt >= GATE_V) |=> (rdy_cnt == $past(rdy_cnt) - 1'b1));

   assert_fresh_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rdy_cnt) == '0 && rdy_cnt != '0) |-> (rdy_cnt == ACC_V));

   assert_read_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rdy_cnt == '0 && $past(rdy_cnt) == '0) |-> $stable(cmd_rdata));
endmodule

bind sram_pipe_slave sram_pipe_slave_chk #(
   .DATA_W(DATA_W), .ACC_CYC(ACC_CYC), .PIPE_LVL(PIPE_LVL), .CNT_W(CNT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rdy_cnt   (rdy_cnt),
   .cmd_rdata (cmd_rdata),
   .sram_ncs  (sram_ncs),
   .sram_noe  (sram_noe),
   .sram_nwe  (sram_nwe)
);

// File: tb/sram_pipe_slave_bench.sv
module sps_bench_ram (
   input  logic       clk,
   input  logic [7:0] a,
   inout  wire  [15:0] dq,
   input  logic       ncs,
   input  logic       noe,
   input  logic       nwe
);
   logic [15:0] mem [256];
   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 16'hA500 ^ 16'(i);
   end
   always @(posedge clk) begin
      if (!ncs && !nwe) mem[a] <= dq;
   end
   assign dq = (!ncs && !noe) ? mem[a] : 'z;
endmodule

module sram_pipe_slave_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   // instance A: level 3
   logic        a_rd = 0, a_wr = 0;
   logic [7:0]  a_addr = 0;
   logic [15:0] a_wdata = 0;
   logic [15:0] a_rdata;
   logic [1:0]  a_cnt, a_lvl;
   logic [7:0]  a_saddr;
   wire  [15:0] a_dq;
   logic        a_ncs, a_noe, a_nwe;

   // instance B: level 0
   logic        b_rd = 0, b_wr = 0;
   logic [7:0]  b_addr = 0;
   logic [15:0] b_rdata;
   logic [1:0]  b_cnt, b_lvl;
   logic [7:0]  b_saddr;
   wire  [15:0] b_dq;
   logic        b_ncs, b_noe, b_nwe;

   sram_pipe_slave #(.ADDR_W(8), .DATA_W(16), .ACC_CYC(2), .PIPE_LVL(3)) u_sram_pipe_slave (
      .clk(clk), .rst_n(rst_n), .cmd_rd(a_rd), .cmd_wr(a_wr), .cmd_addr(a_addr),
      .cmd_wdata(a_wdata), .cmd_rdata(a_rdata), .rdy_cnt(a_cnt), .pipe_level(a_lvl),
      .sram_addr(a_saddr), .sram_dq(a_dq), .sram_ncs(a_ncs), .sram_noe(a_noe), .sram_nwe(a_nwe)
   );
   sps_bench_ram u_ram_a (.clk(clk), .a(a_saddr), .dq(a_dq), .ncs(a_ncs), .noe(a_noe), .nwe(a_nwe));

   sram_pipe_slave #(.ADDR_W(8), .DATA_W(16), .ACC_CYC(2), .PIPE_LVL(0)) u_sram_pipe_slave_l0 (
      .clk(clk), .rst_n(rst_n), .cmd_rd(b_rd), .cmd_wr(b_wr), .cmd_addr(b_addr),
      .cmd_wdata(16'h0000), .cmd_rdata(b_rdata), .rdy_cnt(b_cnt), .pipe_level(b_lvl),
      .sram_addr(b_saddr), .sram_dq(b_dq), .sram_ncs(b_ncs), .sram_noe(b_noe), .sram_nwe(b_nwe)
   );
   sps_bench_ram u_ram_b (.clk(clk), .a(b_saddr), .dq(b_dq), .ncs(b_ncs), .noe(b_noe), .nwe(b_nwe));

   // {is_write, addr, data}
   localparam logic [24:0] VEC [9] = '{
      {1'b1, 8'h10, 16'h1234}, {1'b1, 8'h20, 16'hBEEF}, {1'b1, 8'h30, 16'h0F0F},
      {1'b0, 8'h10, 16'h0000}, {1'b0, 8'h20, 16'h0000}, {1'b0, 8'h30, 16'h0000},
      {1'b0, 8'h44, 16'h0000}, {1'b1, 8'h44, 16'h5A5A}, {1'b0, 8'h44, 16'h0000}
   };

   logic [15:0] shadow [256];

   function automatic logic [15:0] seed(input int i);
      return 16'hA500 ^ 16'(i);
   endfunction

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic a_cmd(input logic we, input logic [7:0] ad, input logic [15:0] d);
      a_rd = !we; a_wr = we; a_addr = ad; a_wdata = d;
      tick();
      a_rd = 0; a_wr = 0;
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 256; i++) shadow[i] = seed(i);
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset state
      chk("R1 ncs", a_ncs, 1); chk("R1 noe", a_noe, 1); chk("R1 nwe", a_nwe, 1);
      chk("R1 count", a_cnt, 0); chk("R1 rdata", a_rdata, 0);
      chk("R1 level A", a_lvl, 3); chk("R1 level B", b_lvl, 0);
      tick();

      // table walk: isolated accesses
      for (int k = 0; k < 9; k++) begin
         logic [24:0] v;
         v = VEC[k];
         a_cmd(v[24], v[23:16], v[15:0]);
         chk("R2 count after capture", a_cnt, 2);
         chk("R10 address on RAM", a_saddr, v[23:16]);
         if (v[24]) begin
            chk("R3 write enable low", a_nwe, 0);
            chk("R3 data driven", a_dq, v[15:0]);
         end else begin
            chk("R10 output enable low", a_noe, 0);
         end
         tick();
         chk("R2 count mid", a_cnt, 1);
         chk("R5 select held", a_ncs, 0);
         tick();
         chk("R2 count done", a_cnt, 0);
         chk("R5 select released", a_ncs, 1);
         if (v[24]) shadow[v[23:16]] = v[15:0];
         else chk("R2 read data", a_rdata, shadow[v[23:16]]);
         tick();
      end

      // R4: hold across a write and idle cycles
      a_cmd(1'b1, 8'h50, 16'h7777);
      shadow[8'h50] = 16'h7777;
      tick(); tick();
      chk("R4 hold after write", a_rdata, 16'h5A5A);
      tick(); tick(); tick();
      chk("R4 hold idle", a_rdata, 16'h5A5A);

      // R7: both strobes at once
      a_rd = 1; a_wr = 1; a_addr = 8'h20;
      tick();
      a_rd = 0; a_wr = 0;
      chk("R7 dual strobe count", a_cnt, 0);
      chk("R7 dual strobe select", a_ncs, 1);
      chk("R7 dual strobe rdata", a_rdata, 16'h5A5A);
      tick();

      // R9 / R8: level-3 waiting slot, plus a premature third command
      a_cmd(1'b0, 8'h10, 16'h0);
      chk("R2 first of pair", a_cnt, 2);
      a_rd = 1; a_addr = 8'h20;
      tick();
      a_addr = 8'h30;
      chk("R8 count with waiting slot", a_cnt, 3);
      tick();
      a_rd = 0;
      chk("R9 count newer", a_cnt, 2);
      chk("R9 older word first", a_rdata, shadow[8'h10]);
      tick();
      chk("R9 count newer mid", a_cnt, 1);
      tick();
      chk("R9 newer done", a_cnt, 0);
      chk("R9 newer word", a_rdata, shadow[8'h20]);
      tick();
      chk("R7 premature command dropped", a_cnt, 0);
      chk("R7 premature command no read", a_rdata, shadow[8'h20]);

      // R8: level-2 point overlap
      a_cmd(1'b0, 8'h30, 16'h0);
      tick();
      chk("R8 count before overlap", a_cnt, 1);
      a_rd = 1; a_addr = 8'h44;
      tick();
      a_rd = 0;
      chk("R8 overlap reload", a_cnt, 2);
      chk("R8 older word", a_rdata, shadow[8'h30]);
      tick(); tick();
      chk("R8 newer done", a_cnt, 0);
      chk("R8 newer word", a_rdata, shadow[8'h44]);

      // R6: level-0 instance refuses busy and result cycles
      b_rd = 1; b_addr = 8'h05;
      tick();
      b_addr = 8'h06;
      chk("R6 L0 loaded", b_cnt, 2);
      tick();
      chk("R6 L0 busy refused", b_cnt, 1);
      tick();
      chk("R6 L0 result", b_cnt, 0);
      chk("R6 L0 first word", b_rdata, seed(5));
      tick();
      chk("R6 L0 result cycle refused", b_cnt, 0);
      tick();
      b_rd = 0;
      chk("R6 L0 accepted after gap", b_cnt, 2);
      tick(); tick();
      chk("R6 L0 second done", b_cnt, 0);
      chk("R6 L0 second word", b_rdata, seed(6));

      finished = 1'b1;
      summary();
      $finish;
   end
endmodule